// File: doc/BRIEF.md
# ECC event reporter and halt controller

This block sits between the error-check logic of a processor core's internal memories and the rest of the chip. Each cycle it receives one valid flag and one severity flag per memory (general-purpose register file, the data and tag arrays of both caches, up to four tightly coupled memories and an optional floating-point register file). It reduces all of them to a single registered report: a 2-bit status and a 4-bit source code that an external monitor can watch. A correctable error is only reported and the core keeps running. An uncorrectable error latches a stall request to the core that nothing but a reset removes.

Two reset paths clear the stall. The hard reset (`rst_n`, asynchronous, active low) clears everything at once. The core-only path works through the controller: a request while stalled makes the block wait for the core to report that its outstanding operations have drained. It then pulses an acknowledge and releases the stall in the same cycle.

The controller has four states. RUN accepts events. HALT holds the stall and the first fatal report. DRAIN holds the stall while the drain completes. ACK is the one-cycle acknowledge, and it also accepts events. The transitions are:
- RUN→HALT on a winning uncorrectable event.
- HALT→DRAIN on `core_rst_req`.
- DRAIN→ACK on `drain_done`.
- ACK→HALT on an uncorrectable event, otherwise ACK→RUN.
- Any state→RUN on hard reset.

Top module: `ecc_halt_ctrl`

## Requirements
- R1: `ecc_status` uses 2'b00 for no event, 2'b10 for a correctable error and 2'b11 for an uncorrectable error; 2'b01 is never driven.
- R2: Event bit i of `evt_valid`/`evt_uncorr` has source code i+1: 1 register file, 2 I-cache data, 3 I-cache tag, 4 D-cache data, 5 D-cache tag, 6 I-TCM1, 7 I-TCM2, 8 D-TCM1, 9 D-TCM2, 10 FP register file. With no event the source is 4'b0000. Codes 11 to 15 never appear.
- R3: The report appears in the cycle after the clock edge that samples the event, lasts one cycle, and returns to 00/0000 in a cycle with no event (outside the stall).
- R4: Sources 6 to 10 are ignored unless enabled by `opt_present` (bit0 I-TCM1, bit1 I-TCM2, bit2 D-TCM1, bit3 D-TCM2, bit4 FPU). Sources 1 to 5 are always honoured.
- R5: When events arrive together, any uncorrectable event wins over every correctable one.
- R6: Among events of equal severity, the lowest source code is reported.
- R7: A correctable event never raises `core_halt`.
- R8: An uncorrectable event raises `core_halt` one cycle after it is sampled. While stalled, the first fatal status and source stay on the outputs and further events are ignored.
- R9: `core_rst_req` has no effect unless the block is stalled: `core_rst_ack` stays low.
- R10: A core reset request while stalled keeps `core_halt` high until `drain_done` is sampled. The next cycle shows `core_rst_ack` high for exactly one cycle, with `core_halt` low and status 00.
- R11: Hard reset asynchronously clears status, source, halt and acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| evt_valid | input | 10 | Per-source event flag, bit i = source code i+1 |
| evt_uncorr | input | 10 | Per-source severity, 1 = uncorrectable |
| opt_present | input | 5 | Presence of I-TCM1, I-TCM2, D-TCM1, D-TCM2, FPU |
| core_rst_req | input | 1 | Core-only reset request |
| drain_done | input | 1 | Core reports outstanding operations drained |
| ecc_status | output | 2 | Registered event status |
| ecc_source | output | 4 | Registered event source code |
| core_halt | output | 1 | Stall request to the core |
| core_rst_ack | output | 1 | One-cycle acknowledge of the core-only reset |

## Verification
The checker watches the output relationships on every cycle. It confirms that the reserved status and the unused source codes never appear, that status and source are zero together, that the stall keeps a frozen 11 report, that the acknowledge is a lone pulse with the stall low, and that the stall only falls on an acknowledge. Which source wins among simultaneous events, the masking by the presence flags, the one-cycle timing and the drain wait depend on the stimulus, so only the bench's vector table and directed sequences can show them.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

    localparam int SRC_W  = 4;
    localparam int N_SRC  = 10;
    localparam int N_OPT  = 5;

    typedef enum logic [1:0] {
        STAT_NONE   = 2'b00,
        STAT_RSVD   = 2'b01,
        STAT_CORR   = 2'b10,
        STAT_UNCORR = 2'b11
    } ecc_stat_e;

    typedef enum logic [1:0] {
        S_RUN   = 2'b00,
        S_HALT  = 2'b01,
        S_DRAIN = 2'b10,
        S_ACK   = 2'b11
    } ctl_state_e;

endpackage

// File: rtl/ecc_src_gate.sv
module ecc_src_gate #(
    parameter int N_SRC = ecc_rpt_pkg::N_SRC,
    parameter int N_OPT = ecc_rpt_pkg::N_OPT
) (
    input  logic [N_SRC-1:0] evt_valid,
    input  logic [N_SRC-1:0] evt_uncorr,
    input  logic [N_OPT-1:0] opt_present,
    output logic [N_SRC-1:0] corr_req,
    output logic [N_SRC-1:0] unc_req
);
    localparam int N_FIXED = N_SRC - N_OPT;

    logic [N_SRC-1:0] src_en;

    // fixed sources are always live, optional ones follow their presence flag
    for (genvar i = 0; i < N_SRC; i++) begin : g_en
        if (i < N_FIXED) begin : g_fixed
            assign src_en[i] = 1'b1;
        end else begin : g_opt
            assign src_en[i] = opt_present[i - N_FIXED];
        end
    end

    assign unc_req  = evt_valid & src_en & evt_uncorr;
    assign corr_req = evt_valid & src_en & ~evt_uncorr;

endmodule

// File: rtl/ecc_evt_pick.sv
module ecc_evt_pick #(
    parameter int N_SRC = ecc_rpt_pkg::N_SRC,
    parameter int SRC_W = ecc_rpt_pkg::SRC_W
) (
    input  logic [N_SRC-1:0] corr_req,
    input  logic [N_SRC-1:0] unc_req,
    output logic             hit,
    output logic             hit_unc,
    output logic [SRC_W-1:0] hit_code
);
    logic [N_SRC-1:0] pool;

    always_comb begin
        hit_unc  = |unc_req;
        pool     = hit_unc ? unc_req : corr_req;
        hit      = |pool;
        hit_code = '0;
        // scan downward so the lowest set index is the last one written
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pool[i]) begin
                hit_code = SRC_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/ecc_halt_fsm.sv
module ecc_halt_fsm
    import ecc_rpt_pkg::*;
#(
    parameter int SRC_W = ecc_rpt_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             hit_unc,
    input  logic [SRC_W-1:0] hit_code,
    input  logic             core_rst_req,
    input  logic             drain_done,
    output logic [1:0]       status,
    output logic [SRC_W-1:0] source,
    output logic             halt,
    output logic             ack
);
    ctl_state_e state, nxt;
    logic       accepting;

    assign accepting = (state == S_RUN) || (state == S_ACK);

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:   if (hit && hit_unc) nxt = S_HALT;
            S_HALT:  if (core_rst_req)   nxt = S_DRAIN;
            S_DRAIN: if (drain_done)     nxt = S_ACK;
            S_ACK:   nxt = (hit && hit_unc) ? S_HALT : S_RUN;
            default: nxt = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= STAT_NONE;
            source <= '0;
            halt   <= 1'b0;
            ack    <= 1'b0;
        end else begin
            halt <= (nxt == S_HALT) || (nxt == S_DRAIN);
            ack  <= (nxt == S_ACK);
            if (accepting) begin
                if (hit) begin
                    status <= hit_unc ? STAT_UNCORR : STAT_CORR;
                    source <= hit_code;
                end else begin
                    status <= STAT_NONE;
                    source <= '0;
                end
            end else if (nxt == S_ACK) begin
                status <= STAT_NONE;
                source <= '0;
            end
        end
    end

endmodule

// File: rtl/ecc_halt_ctrl.sv
module ecc_halt_ctrl
    import ecc_rpt_pkg::*;
#(
    parameter int N_SRC = ecc_rpt_pkg::N_SRC,
    parameter int N_OPT = ecc_rpt_pkg::N_OPT,
    parameter int SRC_W = ecc_rpt_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_valid,
    input  logic [N_SRC-1:0] evt_uncorr,
    input  logic [N_OPT-1:0] opt_present,
    input  logic             core_rst_req,
    input  logic             drain_done,
    output logic [1:0]       ecc_status,
    output logic [SRC_W-1:0] ecc_source,
    output logic             core_halt,
    output logic             core_rst_ack
);
    logic [N_SRC-1:0] corr_req, unc_req;
    logic             hit, hit_unc;
    logic [SRC_W-1:0] hit_code;

    ecc_src_gate #(.N_SRC(N_SRC), .N_OPT(N_OPT)) u_gate (
        .evt_valid   (evt_valid),
        .evt_uncorr  (evt_uncorr),
        .opt_present (opt_present),
        .corr_req    (corr_req),
        .unc_req     (unc_req)
    );

    ecc_evt_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick (
        .corr_req (corr_req),
        .unc_req  (unc_req),
        .hit      (hit),
        .hit_unc  (hit_unc),
        .hit_code (hit_code)
    );

    ecc_halt_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .hit_unc      (hit_unc),
        .hit_code     (hit_code),
        .core_rst_req (core_rst_req),
        .drain_done   (drain_done),
        .status       (ecc_status),
        .source       (ecc_source),
        .halt         (core_halt),
        .ack          (core_rst_ack)
    );

endmodule

// File: rtl/ecc_halt_ctrl_chk.sv
module ecc_halt_ctrl_chk #(
    parameter int SRC_W = ecc_rpt_pkg::SRC_W,
    parameter int N_SRC = ecc_rpt_pkg::N_SRC
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ecc_status,
    input logic [SRC_W-1:0] ecc_source,
    input logic             core_halt,
    input logic             core_rst_ack
);
    // R1
    rsvd_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_status != 2'b01);

    // R2
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_source <= SRC_W'(N_SRC));

    // R2
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_status == 2'b00) == (ecc_source == '0));

    // R7
    halt_is_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> (ecc_status == 2'b11));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |=> (!core_halt || ($stable(ecc_status) && $stable(ecc_source))));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_ack |=> !core_rst_ack);

    // R10
    ack_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_ack |-> (!core_halt && ecc_status == 2'b00));

    // R10
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_halt) |-> core_rst_ack);

endmodule

bind ecc_halt_ctrl ecc_halt_ctrl_chk #(.SRC_W(SRC_W), .N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ecc_status   (ecc_status),
    .ecc_source   (ecc_source),
    .core_halt    (core_halt),
    .core_rst_ack (core_rst_ack)
);

// File: tb/ecc_halt_ctrl_test.sv
`timescale 1ns/1ps
module ecc_halt_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] evt_valid = '0;
    logic [9:0] evt_uncorr = '0;
    logic [4:0] opt_present = '0;
    logic       core_rst_req = 1'b0;
    logic       drain_done = 1'b0;
    logic [1:0] ecc_status;
    logic [3:0] ecc_source;
    logic       core_halt;
    logic       core_rst_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecc_halt_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_uncorr   (evt_uncorr),
        .opt_present  (opt_present),
        .core_rst_req (core_rst_req),
        .drain_done   (drain_done),
        .ecc_status   (ecc_status),
        .ecc_source   (ecc_source),
        .core_halt    (core_halt),
        .core_rst_ack (core_rst_ack)
    );

    // {valid, uncorr, present, exp_status, exp_source}; all rows stay out of the stall
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {10'b0000000000, 10'b0000000000, 5'b11111, 2'b00, 4'd0},  // R3 idle
        {10'b0000000001, 10'b0000000000, 5'b11111, 2'b10, 4'd1},  // R2 reg file
        {10'b0000001000, 10'b0000000000, 5'b11111, 2'b10, 4'd4},  // R2 dcache data
        {10'b0010000100, 10'b0000000000, 5'b11111, 2'b10, 4'd3},  // R6 lowest wins
        {10'b0000100000, 10'b0000000000, 5'b11110, 2'b00, 4'd0},  // R4 itcm1 absent
        {10'b0000100000, 10'b0000000000, 5'b00001, 2'b10, 4'd6},  // R4 itcm1 present
        {10'b1000000000, 10'b0000000000, 5'b01111, 2'b00, 4'd0},  // R4 fpu absent
        {10'b1000000000, 10'b0000000000, 5'b10000, 2'b10, 4'd10}, // R2 fpu
        {10'b0100100000, 10'b0000000000, 5'b01000, 2'b10, 4'd9},  // R4 only dtcm2
        {10'b0001010000, 10'b0001000000, 5'b11101, 2'b10, 4'd5},  // R4 masked fatal
        {10'b1000000010, 10'b0000000000, 5'b11111, 2'b10, 4'd2},  // R6
        {10'b1000000000, 10'b1000000000, 5'b01111, 2'b00, 4'd0}   // R7 masked fatal
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [9:0] v, input logic [9:0] u, input logic [4:0] p);
        evt_valid   = v;
        evt_uncorr  = u;
        opt_present = p;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input int st, input int src,
                              input int hl, input int ak);
        check({req, " status"}, ecc_status, st);
        check({req, " source"}, ecc_source, src);
        check({req, " halt"}, core_halt, hl);
        check({req, " ack"}, core_rst_ack, ak);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R11 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: request and drain while running give no acknowledge
        core_rst_req = 1'b1;
        drain_done   = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step('0, '0, 5'b11111);
            expect_out("R9", 0, 0, 0, 0);
        end
        core_rst_req = 1'b0;
        drain_done   = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][30:21], VEC[k][20:11], VEC[k][10:6]);
            check("R1 R2 R3 table status", ecc_status, int'(VEC[k][5:4]));
            check("R2 R4 R6 table source", ecc_source, int'(VEC[k][3:0]));
            check("R7 table halt", core_halt, 0);
        end

        // R5: fatal dcache tag beats correctable reg file
        step(10'b0000010001, 10'b0000010000, 5'b11111);
        expect_out("R5", 3, 5, 1, 0);
        // R8: later events ignored while stalled
        step(10'b0000000001, 10'b0000000001, 5'b11111);
        expect_out("R8 hold fatal", 3, 5, 1, 0);
        step(10'b0000000010, 10'b0000000000, 5'b11111);
        expect_out("R8 hold corr", 3, 5, 1, 0);

        // R10: drain wait
        core_rst_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step('0, '0, 5'b11111);
            expect_out("R10 drain wait", 3, 5, 1, 0);
            core_rst_req = 1'b0;
        end
        drain_done = 1'b1;
        step('0, '0, 5'b11111);
        expect_out("R10 ack", 0, 0, 0, 1);
        drain_done = 1'b0;
        step('0, '0, 5'b11111);
        expect_out("R10 after ack", 0, 0, 0, 0);

        // R7 / R3 after release
        step(10'b0000000100, 10'b0000000000, 5'b11111);
        expect_out("R7 corr after release", 2, 3, 0, 0);
        step('0, '0, 5'b11111);
        expect_out("R3 back to idle", 0, 0, 0, 0);

        // R6: two fatal events, lowest code wins
        step(10'b0010000100, 10'b0010000100, 5'b11111);
        expect_out("R6 fatal pair", 3, 3, 1, 0);

        // R11: hard reset while stalled
        rst_n = 1'b0;
        #2;
        expect_out("R11 async clear", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step('0, '0, 5'b11111);
        expect_out("R11 after reset", 0, 0, 0, 0);

        // R4: fatal event from an absent FPU does nothing
        step(10'b1000000000, 10'b1000000000, 5'b00000);
        expect_out("R4 fatal absent", 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule